// File: doc/BRIEF.md
# Tagged Floating-Point Register File

This block holds the architectural floating-point registers of an out-of-order core. Each register has a data value and a producer tag. The producer tag names the reservation station that will deliver the register's next value. A tag of zero means the register already holds its final value.

When an instruction issues, the block reads its two source registers. For each source it reports either a value or the tag of the station still computing it. In the same cycle it stamps the destination register with the tag of the station that will write it.

Results do not arrive by register address. They come on a broadcast bus as a (tag, data) pair. Every register still waiting on that tag captures the data and returns to the ready state. Because each new issue overwrites the destination's tag, a stale producer can no longer land in that register. This removes write-after-read and write-after-write hazards on register names.

Each register is a two-state machine:

- `ENT_READY`: the tag is zero and the value is valid.
- `ENT_WAIT`: the tag is nonzero and a station is still computing the value.

The transitions are:

- *claim*: an issue with a nonzero tag moves the register from `ENT_READY` or `ENT_WAIT` to `ENT_WAIT`.
- *hit*: a broadcast whose tag matches the held tag moves the register from `ENT_WAIT` to `ENT_READY`.
- *hold*: with neither a claim nor a hit, the register stays in its current state.

When a claim and a hit reach the same register in the same cycle, the claim wins.

Top module: `tagged_fp_regfile`

## Requirements
- R1: After reset every register is ready with value zero, so a read returns tag 0 and value 0.
- R2: A read of a ready register returns its stored value with tag 0, in the same cycle the index is presented.
- R3: An issue with a nonzero tag writes that tag into the destination from the next cycle on. A read of a waiting register returns the tag and value 0.
- R4: A broadcast loads its data into every register whose held tag equals the broadcast tag and sets those registers' tags to 0. The new value is readable from the next cycle.
- R5: A broadcast leaves ready registers and registers holding a different tag unchanged. A broadcast with tag 0 changes nothing.
- R6: Re-issuing to a waiting register replaces its tag. A later broadcast of the old tag then leaves the register waiting on the new tag.
- R7: When a broadcast clears a register and an issue retags that same register in the same cycle, the register ends up waiting on the new tag.
- R8: A read of a register whose held tag equals the tag of a broadcast in that same cycle returns the broadcast data with tag 0.
- R9: A read of the register that is the destination of an issue in the same cycle returns that register's state from before the issue.
- R10: An issue with tag 0 has no effect on the destination register.
- R11: The two read ports are independent. The same index presented to both ports gives identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_en | input | 1 | Issue strobe: stamp the destination with a tag |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Station tag for the destination (0 is ignored) |
| src_a_idx | input | 4 | Read port A register index |
| src_a_val | output | 64 | Port A value (0 while the register is waiting) |
| src_a_tag | output | 4 | Port A producer tag (0 when the value is valid) |
| src_b_idx | input | 4 | Read port B register index |
| src_b_val | output | 64 | Port B value (0 while the register is waiting) |
| src_b_tag | output | 4 | Port B producer tag (0 when the value is valid) |
| bus_en | input | 1 | Result broadcast valid |
| bus_tag | input | 4 | Tag of the station broadcasting |
| bus_data | input | 64 | Broadcast result value |

## Verification
The bench builds the block with its default parameters: 16 registers, 64-bit values and 4-bit tags. With these values, station tags up to 15 are available. Full-width data patterns show that values are not truncated. The index range lets two unrelated registers share a tag, so the all-matching broadcast of R4 can be checked. The default widths also allow the same-cycle collisions of claim, hit and read (R7, R8, R9) to be set up on a single register.

// File: rtl/rf_tag_pkg.sv
package rf_tag_pkg;
    parameter int RF_REGS   = 16;
    parameter int RF_DATA_W = 64;
    parameter int RF_TAG_W  = 4;

    typedef enum logic {
        ENT_READY = 1'b0,
        ENT_WAIT  = 1'b1
    } ent_state_e;
endpackage

// File: rtl/rf_tag_entry.sv
module rf_tag_entry
    import rf_tag_pkg::*;
#(
    parameter int DATA_W = RF_DATA_W,
    parameter int TAG_W  = RF_TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [TAG_W-1:0]  new_tag,
    input  logic              bus_en,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] val_o
);
    ent_state_e        st_q, st_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] val_q, val_d;
    logic              hit, claim;

    always_comb begin
        hit   = bus_en && (st_q == ENT_WAIT) && (bus_tag == tag_q);
        claim = wr_sel && (new_tag != '0);
        st_d  = st_q;
        tag_d = tag_q;
        val_d = val_q;
        unique case (st_q)
            ENT_READY: begin
                if (claim) begin
                    st_d  = ENT_WAIT;
                    tag_d = new_tag;
                end
            end
            ENT_WAIT: begin
                if (hit) begin
                    val_d = bus_data;
                    st_d  = ENT_READY;
                    tag_d = '0;
                end
                if (claim) begin
                    st_d  = ENT_WAIT;
                    tag_d = new_tag;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ENT_READY;
            tag_q <= '0;
            val_q <= '0;
        end else begin
            st_q  <= st_d;
            tag_q <= tag_d;
            val_q <= val_d;
        end
    end

    always_comb begin
        tag_o = tag_q;
        val_o = val_q;
    end

    AST_READY_MEANS_ZERO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENT_READY) == (tag_q == '0)); // R1
    AST_HIT_LOADS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !claim) |=> (st_q == ENT_READY && tag_q == '0 && val_q == $past(bus_data))); // R4
    AST_CLAIM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> (st_q == ENT_WAIT && tag_q == $past(new_tag))); // R7
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !claim) |=> ($stable(tag_q) && $stable(val_q))); // R5
endmodule

// File: rtl/rf_tag_readport.sv
module rf_tag_readport
    import rf_tag_pkg::*;
#(
    parameter int NUM    = RF_REGS,
    parameter int DATA_W = RF_DATA_W,
    parameter int TAG_W  = RF_TAG_W,
    localparam int IDX_W = $clog2(NUM)
) (
    input  logic [IDX_W-1:0]          idx,
    input  logic [NUM-1:0][TAG_W-1:0]  tags,
    input  logic [NUM-1:0][DATA_W-1:0] vals,
    input  logic                      bus_en,
    input  logic [TAG_W-1:0]          bus_tag,
    input  logic [DATA_W-1:0]         bus_data,
    output logic [DATA_W-1:0]         val_o,
    output logic [TAG_W-1:0]          tag_o
);
    logic [TAG_W-1:0] sel_tag;

    always_comb begin
        sel_tag = tags[idx];
        if (sel_tag == '0) begin
            val_o = vals[idx];
            tag_o = '0;
        end else if (bus_en && bus_tag == sel_tag) begin
            val_o = bus_data;
            tag_o = '0;
        end else begin
            val_o = '0;
            tag_o = sel_tag;
        end
    end
endmodule

// File: rtl/tagged_fp_regfile.sv
module tagged_fp_regfile
    import rf_tag_pkg::*;
#(
    parameter int NUM    = RF_REGS,
    parameter int DATA_W = RF_DATA_W,
    parameter int TAG_W  = RF_TAG_W,
    localparam int IDX_W = $clog2(NUM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_en,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic [IDX_W-1:0]  src_a_idx,
    output logic [DATA_W-1:0] src_a_val,
    output logic [TAG_W-1:0]  src_a_tag,
    input  logic [IDX_W-1:0]  src_b_idx,
    output logic [DATA_W-1:0] src_b_val,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              bus_en,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data
);
    logic [NUM-1:0][TAG_W-1:0]  tag_arr;
    logic [NUM-1:0][DATA_W-1:0] val_arr;

    for (genvar g = 0; g < NUM; g++) begin : g_ent
        logic sel;
        assign sel = iss_en && (iss_dst == IDX_W'(g));
        rf_tag_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) ent_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (sel),
            .new_tag  (iss_tag),
            .bus_en   (bus_en),
            .bus_tag  (bus_tag),
            .bus_data (bus_data),
            .tag_o    (tag_arr[g]),
            .val_o    (val_arr[g])
        );
    end

    rf_tag_readport #(.NUM(NUM), .DATA_W(DATA_W), .TAG_W(TAG_W)) rd_a_i (
        .idx(src_a_idx), .tags(tag_arr), .vals(val_arr),
        .bus_en(bus_en), .bus_tag(bus_tag), .bus_data(bus_data),
        .val_o(src_a_val), .tag_o(src_a_tag)
    );

    rf_tag_readport #(.NUM(NUM), .DATA_W(DATA_W), .TAG_W(TAG_W)) rd_b_i (
        .idx(src_b_idx), .tags(tag_arr), .vals(val_arr),
        .bus_en(bus_en), .bus_tag(bus_tag), .bus_data(bus_data),
        .val_o(src_b_val), .tag_o(src_b_tag)
    );

    AST_NO_STALE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_tag != '0) |-> !(bus_en && bus_tag == src_a_tag)); // R8
    AST_PENDING_VALUE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (src_b_tag != '0) |-> (src_b_val == '0)); // R3
    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_idx == src_b_idx) |-> (src_a_tag == src_b_tag && src_a_val == src_b_val)); // R11
endmodule

// File: tb/tagged_fp_regfile_tb.sv
module tagged_fp_regfile_tb_top;
    typedef struct packed {
        logic        ien;
        logic [3:0]  idst;
        logic [3:0]  itag;
        logic        ben;
        logic [3:0]  btag;
        logic [63:0] bdata;
        logic [3:0]  aidx;
        logic [3:0]  etag;
        logic [63:0] eval;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 4'd0,  4'd0, 1'b0, 4'd0, 64'h0,                 4'd3,  4'd0, 64'h0,                 8'd1},  // R1 reset value
        '{1'b1, 4'd3,  4'd5, 1'b0, 4'd0, 64'h0,                 4'd3,  4'd0, 64'h0,                 8'd9},  // R9 pre-issue state
        '{1'b0, 4'd0,  4'd0, 1'b0, 4'd0, 64'h0,                 4'd3,  4'd5, 64'h0,                 8'd3},  // R3 tag visible
        '{1'b0, 4'd0,  4'd0, 1'b1, 4'd5, 64'h1111_2222_3333_4444, 4'd3, 4'd0, 64'h1111_2222_3333_4444, 8'd8},  // R8 bypass
        '{1'b0, 4'd0,  4'd0, 1'b0, 4'd0, 64'h0,                 4'd3,  4'd0, 64'h1111_2222_3333_4444, 8'd2},  // R2 stored
        '{1'b1, 4'd3,  4'd6, 1'b0, 4'd0, 64'h0,                 4'd4,  4'd0, 64'h0,                 8'd2},  // R2 other reg
        '{1'b1, 4'd3,  4'd7, 1'b0, 4'd0, 64'h0,                 4'd3,  4'd6, 64'h0,                 8'd3},  // R3 first tag
        '{1'b0, 4'd0,  4'd0, 1'b1, 4'd6, 64'hDEAD_0000_0000_0022, 4'd3, 4'd7, 64'h0,                 8'd6},  // R6 old tag no bypass
        '{1'b0, 4'd0,  4'd0, 1'b0, 4'd0, 64'h0,                 4'd3,  4'd7, 64'h0,                 8'd6},  // R6 still waiting
        '{1'b1, 4'd3,  4'd8, 1'b1, 4'd7, 64'h0000_0000_0000_0033, 4'd3, 4'd0, 64'h33,                8'd8},  // R8 bypass during R7
        '{1'b0, 4'd0,  4'd0, 1'b0, 4'd0, 64'h0,                 4'd3,  4'd8, 64'h0,                 8'd7},  // R7 new tag wins
        '{1'b0, 4'd0,  4'd0, 1'b1, 4'd0, 64'h44,                4'd4,  4'd0, 64'h0,                 8'd5},  // R5 tag zero bcast
        '{1'b1, 4'd4,  4'd0, 1'b0, 4'd0, 64'h0,                 4'd4,  4'd0, 64'h0,                 8'd10}, // R10 zero tag issue
        '{1'b0, 4'd0,  4'd0, 1'b0, 4'd0, 64'h0,                 4'd4,  4'd0, 64'h0,                 8'd10}, // R10 no effect
        '{1'b1, 4'd9,  4'd2, 1'b0, 4'd0, 64'h0,                 4'd9,  4'd0, 64'h0,                 8'd9},  // R9
        '{1'b1, 4'd10, 4'd2, 1'b0, 4'd0, 64'h0,                 4'd9,  4'd2, 64'h0,                 8'd3},  // R3
        '{1'b0, 4'd0,  4'd0, 1'b1, 4'd2, 64'hFFFF_FFFF_FFFF_FF55, 4'd10, 4'd0, 64'hFFFF_FFFF_FFFF_FF55, 8'd8},  // R8
        '{1'b0, 4'd0,  4'd0, 1'b0, 4'd0, 64'h0,                 4'd9,  4'd0, 64'hFFFF_FFFF_FFFF_FF55, 8'd4},  // R4 first match
        '{1'b0, 4'd0,  4'd0, 1'b0, 4'd0, 64'h0,                 4'd10, 4'd0, 64'hFFFF_FFFF_FFFF_FF55, 8'd4},  // R4 second match
        '{1'b0, 4'd0,  4'd0, 1'b1, 4'd8, 64'h66,                4'd9,  4'd0, 64'hFFFF_FFFF_FFFF_FF55, 8'd5},  // R5 other tag
        '{1'b0, 4'd0,  4'd0, 1'b0, 4'd0, 64'h0,                 4'd3,  4'd0, 64'h66,                8'd4}   // R4 late result
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_en = 1'b0;
    logic [3:0]  iss_dst = '0, iss_tag = '0;
    logic [3:0]  src_a_idx = '0, src_b_idx = '0;
    logic [63:0] src_a_val, src_b_val;
    logic [3:0]  src_a_tag, src_b_tag;
    logic        bus_en = 1'b0;
    logic [3:0]  bus_tag = '0;
    logic [63:0] bus_data = '0;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tagged_fp_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .iss_en(iss_en), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .src_a_idx(src_a_idx), .src_a_val(src_a_val), .src_a_tag(src_a_tag),
        .src_b_idx(src_b_idx), .src_b_val(src_b_val), .src_b_tag(src_b_tag),
        .bus_en(bus_en), .bus_tag(bus_tag), .bus_data(bus_data)
    );

    task automatic chk(input int req, input logic [3:0] at, input logic [63:0] av,
                       input logic [3:0] et, input logic [63:0] ev);
        checks++;
        if (at !== et || av !== ev) begin
            fails++;
            $display("FAIL R%0d: got tag=%0d val=%h expected tag=%0d val=%h", req, at, av, et, ev);
        end
    endtask

    task automatic idle();
        iss_en = 1'b0; iss_dst = '0; iss_tag = '0;
        bus_en = 1'b0; bus_tag = '0; bus_data = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            iss_en = TBL[i].ien; iss_dst = TBL[i].idst; iss_tag = TBL[i].itag;
            bus_en = TBL[i].ben; bus_tag = TBL[i].btag; bus_data = TBL[i].bdata;
            src_a_idx = TBL[i].aidx; src_b_idx = TBL[i].aidx;
            #1;
            chk(int'(TBL[i].req), src_a_tag, src_a_val, TBL[i].etag, TBL[i].eval);
            chk(11, src_b_tag, src_b_val, TBL[i].etag, TBL[i].eval); // R11 same index
        end
        @(negedge clk);
        idle();
        src_a_idx = 4'd3; src_b_idx = 4'd9;
        #1;
        chk(11, src_a_tag, src_a_val, 4'd0, 64'h66);                  // R11 independent A
        chk(11, src_b_tag, src_b_val, 4'd0, 64'hFFFF_FFFF_FFFF_FF55); // R11 independent B
        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk(1, src_a_tag, src_a_val, 4'd0, 64'h0); // R1 reset clears value
        chk(1, src_b_tag, src_b_val, 4'd0, 64'h0); // R1
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: got no completion expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule